// File: doc/BRIEF.md
# Scan Slice Decompression Decoder

This block rebuilds scan slices from a compressed code stream. The tester sends one slice code per clock. Each code has a 2-bit control field and a data field of `K_W = $clog2(N_CHAINS+1)` bits. The decoder keeps an `N_CHAINS`-bit slice buffer. It changes the buffer one addressed bit at a time, or one run of `K_W` bits at a time, as the control field directs. When a slice is finished, the decoder presents it on a parallel output that feeds the scan chains, together with a one-cycle strobe.

A new slice always starts with an initial code. That code sets the whole buffer to a background level, and the indexed bit takes the opposite level, which is the target symbol. Two kinds of code then add to the slice. A bit code writes the target symbol at one index. A sequence of group codes first loads a start address and then copies literal data into consecutive `K_W`-bit windows. The finished slice leaves the block when the next initial code arrives, or when the flush input is raised.

Top module: `scd_decoder`

## Requirements
- R1: During active-low synchronous reset and in the first cycle after it, `scan_slice` is all zeros, `slice_done` is 0, and the decoder is in its idle state, waiting for an initial code.
- R2: An accepted initial code (control `00` or `01`) takes control bit 0 as the background level and its complement as the target symbol. Every buffer bit is set to the background, except that bit `code_data` is set to the target.
- R3: A data index equal to or above `N_CHAINS` in an initial or bit code writes no buffer bit.
- R4: A bit code (control `10`) sets buffer bit `code_data` to the latched target symbol and leaves every other bit unchanged.
- R5: A group code (control `11`) that follows any non-group code loads `code_data` as the start address and leaves the buffer unchanged.
- R6: Each further consecutive group code writes data bit j into buffer bit (address + j) for j = 0..K_W-1. Positions at or beyond `N_CHAINS` are dropped. The address then advances by `K_W`.
- R7: An initial code received while a slice is open delivers the buffer as it stood before that code. The delivered buffer appears on `scan_slice`, and `slice_done` is high for that one cycle, both one clock after the code. `scan_slice` changes only on delivery.
- R8: Flush delivers an open slice in the same way as R7 and returns the decoder to idle. Any code presented in the same cycle as flush is discarded.
- R9: In the idle state, bit and group codes are ignored: they cause no delivery, and a flush that follows them delivers nothing.
- R10: The address decoder never asserts more than one buffer select line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_valid | input | 1 | A slice code is present this cycle |
| code_ctl | input | 2 | Control field of the slice code |
| code_data | input | K_W | Data field: a bit index, a start address or group literal data |
| flush | input | 1 | Deliver the open slice and return to idle |
| scan_slice | output | N_CHAINS | Last delivered slice, one bit per scan chain |
| slice_done | output | 1 | One-cycle strobe: `scan_slice` holds a newly delivered slice |

## Verification
Directed streams check each code type on its own. A lone bit code checks background fill against the target write. A dummy index at `N_CHAINS` shows that out-of-range writes are dropped. An address-only group run shows that the address load leaves the buffer alone. A merged two-group run followed by a window on the last one-bit group shows the address advance and the dropping of data beyond the buffer. Random slices with care densities that vary from slice to slice are then compressed by an encoder in the bench, using majority background, group copy for windows holding several targets, merging of adjacent windows, and dummy separators. Every delivered slice is compared with its original care bits, and the outputs are compared with a behavioural model on every clock.

// File: rtl/scd_pkg.sv
// Shared types for the scan slice decoder.
// Assumes: nothing beyond the SystemVerilog standard.
package scd_pkg;

    // Decoder sequencing state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for an initial code
        ST_BIT  = 2'd1,   // slice open, last code was not a group code
        ST_GRP  = 2'd2    // slice open, group address loaded
    } scd_state_e;

    // Buffer operation requested by the sequencer for this cycle.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_FILL  = 2'd1,  // background everywhere, target on the select
        OP_BIT   = 2'd2,  // target on the select
        OP_GROUP = 2'd3   // literal window starting at the select
    } scd_op_e;

endpackage

// File: rtl/scd_fsm.sv
// Sequencer: interprets control codes, holds the target symbol and the
// group address, and picks the index that drives the address decoder.
// Assumes: at most one code per cycle; flush has priority over a code.
module scd_fsm
    import scd_pkg::*;
#(
    parameter int N_CHAINS = 16,
    parameter int K_W      = 5,
    parameter int AW       = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           code_valid,
    input  logic [1:0]     code_ctl,
    input  logic [K_W-1:0] code_data,
    input  logic           flush,
    output scd_op_e        buf_op,
    output logic           tgt_sym,
    output logic [AW-1:0]  dec_idx,
    output logic           deliver,
    output logic           in_idle
);

    scd_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          use_addr;
    logic          load_addr;

    logic is_init, is_bit, is_grp;
    assign is_init = code_valid && !code_ctl[1];
    assign is_bit  = code_valid && (code_ctl == 2'b10);
    assign is_grp  = code_valid && (code_ctl == 2'b11);

    // Decide the next state, the buffer operation and delivery.
    always_comb begin
        state_d   = state_q;
        buf_op    = OP_HOLD;
        deliver   = 1'b0;
        use_addr  = 1'b0;
        load_addr = 1'b0;
        if (flush) begin
            deliver = (state_q != ST_IDLE);
            state_d = ST_IDLE;
        end else if (is_init) begin
            deliver = (state_q != ST_IDLE);
            buf_op  = OP_FILL;
            state_d = ST_BIT;
        end else if (state_q != ST_IDLE) begin
            if (is_bit) begin
                buf_op  = OP_BIT;
                state_d = ST_BIT;
            end else if (is_grp) begin
                if (state_q == ST_BIT) begin
                    load_addr = 1'b1;
                    state_d   = ST_GRP;
                end else begin
                    buf_op   = OP_GROUP;
                    use_addr = 1'b1;
                end
            end
        end
    end

    // Select the decoder source: group address or incoming index.
    assign dec_idx = use_addr ? addr_q : AW'(code_data);
    assign in_idle = (state_q == ST_IDLE);

    // Register state, target symbol and group address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_sym <= 1'b1;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!flush && is_init)
                tgt_sym <= ~code_ctl[0];
            if (load_addr)
                addr_q <= AW'(code_data);
            else if (use_addr && (addr_q < AW'(N_CHAINS)))
                addr_q <= addr_q + AW'(K_W);
        end
    end

endmodule

// File: rtl/scd_addr_dec.sv
// Index-to-select decoder: one line per buffer bit, none when out of range.
// Assumes: AW wide enough to hold N_CHAINS.
module scd_addr_dec #(
    parameter int N_CHAINS = 16,
    parameter int AW       = 6
) (
    input  logic [AW-1:0]       idx,
    output logic [N_CHAINS-1:0] sel
);

    // Compare the index against each bit position.
    for (genvar i = 0; i < N_CHAINS; i++) begin : g_sel
        assign sel[i] = (idx == AW'(i));
    end

endmodule

// File: rtl/scd_slice_buf.sv
// Slice buffer with per-bit and per-window writes driven by one-hot selects.
// Assumes: sel has at most one bit set.
module scd_slice_buf
    import scd_pkg::*;
#(
    parameter int N_CHAINS = 16,
    parameter int K_W      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  scd_op_e             buf_op,
    input  logic                bg_in,
    input  logic                tgt_sym,
    input  logic [N_CHAINS-1:0] sel,
    input  logic [K_W-1:0]      grp_data,
    output logic [N_CHAINS-1:0] slice_q
);

    logic [K_W-1:0]      win_hit [N_CHAINS];
    logic [N_CHAINS-1:0] grp_en;
    logic [N_CHAINS-1:0] grp_val;

    // Bit i lies j places after the select: it takes literal bit j.
    for (genvar i = 0; i < N_CHAINS; i++) begin : g_bit
        for (genvar j = 0; j < K_W; j++) begin : g_off
            if (j <= i) begin : g_in
                assign win_hit[i][j] = sel[i-j];
            end else begin : g_out
                assign win_hit[i][j] = 1'b0;
            end
        end
        assign grp_en[i]  = |win_hit[i];
        assign grp_val[i] = |(win_hit[i] & grp_data);
    end

    // Apply the requested operation to every buffer bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_q <= '0;
        end else begin
            for (int i = 0; i < N_CHAINS; i++) begin
                case (buf_op)
                    OP_FILL:  slice_q[i] <= sel[i] ? ~bg_in : bg_in;
                    OP_BIT:   if (sel[i]) slice_q[i] <= tgt_sym;
                    OP_GROUP: if (grp_en[i]) slice_q[i] <= grp_val[i];
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/scd_decoder.sv
// Top: scan slice decoder. Receives slice codes, rebuilds each slice and
// hands finished slices to the scan chains with a one-cycle strobe.
// Assumes: code_data index N_CHAINS (or more) is the dummy no-write index.
module scd_decoder
    import scd_pkg::*;
#(
    parameter int N_CHAINS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          code_valid,
    input  logic [1:0]                    code_ctl,
    input  logic [$clog2(N_CHAINS+1)-1:0] code_data,
    input  logic                          flush,
    output logic [N_CHAINS-1:0]           scan_slice,
    output logic                          slice_done
);

    localparam int K_W = $clog2(N_CHAINS + 1);
    localparam int AW  = K_W + 1;

    scd_op_e             buf_op;
    logic                tgt_sym;
    logic [AW-1:0]       dec_idx;
    logic                deliver;
    logic                in_idle;
    logic [N_CHAINS-1:0] sel_lines;
    logic [N_CHAINS-1:0] slice_q;

    scd_fsm #(.N_CHAINS(N_CHAINS), .K_W(K_W), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid),
        .code_ctl(code_ctl), .code_data(code_data), .flush(flush),
        .buf_op(buf_op), .tgt_sym(tgt_sym), .dec_idx(dec_idx),
        .deliver(deliver), .in_idle(in_idle)
    );

    scd_addr_dec #(.N_CHAINS(N_CHAINS), .AW(AW)) u_dec (
        .idx(dec_idx), .sel(sel_lines)
    );

    scd_slice_buf #(.N_CHAINS(N_CHAINS), .K_W(K_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .buf_op(buf_op), .bg_in(code_ctl[0]),
        .tgt_sym(tgt_sym), .sel(sel_lines), .grp_data(code_data),
        .slice_q(slice_q)
    );

    // Capture the finished slice and raise the strobe on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_slice <= '0;
            slice_done <= 1'b0;
        end else begin
            slice_done <= deliver;
            if (deliver)
                scan_slice <= slice_q;
        end
    end

endmodule

// File: rtl/scd_decoder_chk.sv
// Property checker for the scan slice decoder, bound to the top module.
// Assumes: sampled on the decoder clock, disabled while reset is low.
module scd_decoder_chk #(
    parameter int N_CHAINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                code_valid,
    input logic [1:0]          code_ctl,
    input logic                flush,
    input logic [N_CHAINS-1:0] sel,
    input logic                in_idle,
    input logic [N_CHAINS-1:0] slice_now,
    input logic [N_CHAINS-1:0] scan_slice,
    input logic                slice_done
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R10

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        slice_done |-> $past(flush || (code_valid && !code_ctl[1]))); // R7

    AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_done |-> $stable(scan_slice)); // R7

    AST_FLUSH_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_idle) |=> slice_done); // R8

    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> in_idle); // R8

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && code_valid && code_ctl[1] && !flush)
            |=> (in_idle && $stable(slice_now) && !slice_done)); // R9

endmodule

bind scd_decoder scd_decoder_chk #(.N_CHAINS(N_CHAINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ctl(code_ctl),
    .flush(flush), .sel(sel_lines), .in_idle(in_idle), .slice_now(slice_q),
    .scan_slice(scan_slice), .slice_done(slice_done)
);

// File: tb/scd_decoder_tb.sv
// Self-checking bench: directed code streams, then random slices encoded
// by a behavioural encoder, with a behavioural model compared every clock.
module scd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int K   = $clog2(N + 1);
    localparam int NSL = 200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         code_valid = 1'b0;
    logic [1:0]   code_ctl = 2'b00;
    logic [K-1:0] code_data = '0;
    logic         flush = 1'b0;
    logic [N-1:0] scan_slice;
    logic         slice_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural model state
    int     m_state = 0;     // 0 idle, 1 open, 2 group address loaded
    int     m_addr = 0;
    int     m_tgt = 1;
    bit     m_buf [N];
    bit     exp_done = 1'b0;
    logic [N-1:0] exp_slice = '0;

    // delivered-slice care-bit queue
    logic [N-1:0] care_val_q [$];
    logic [N-1:0] care_msk_q [$];
    bit           care_on = 1'b0;

    // encoded stream
    int ctl_q [$];
    int dat_q [$];

    scd_decoder #(.N_CHAINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ctl(code_ctl),
        .code_data(code_data), .flush(flush),
        .scan_slice(scan_slice), .slice_done(slice_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update(bit v, int c, int d, bit f);
        exp_done = 1'b0;
        if (f) begin
            if (m_state != 0) begin
                for (int i = 0; i < N; i++) exp_slice[i] = m_buf[i];
                exp_done = 1'b1;
            end
            m_state = 0;
        end else if (v && c < 2) begin
            if (m_state != 0) begin
                for (int i = 0; i < N; i++) exp_slice[i] = m_buf[i];
                exp_done = 1'b1;
            end
            m_tgt = 1 - (c % 2);
            for (int i = 0; i < N; i++) m_buf[i] = bit'(c % 2);
            if (d < N) m_buf[d] = bit'(m_tgt);
            m_state = 1;
        end else if (v && m_state != 0 && c == 2) begin
            if (d < N) m_buf[d] = bit'(m_tgt);
            m_state = 1;
        end else if (v && m_state != 0 && c == 3) begin
            if (m_state == 1) begin
                m_addr = d;
                m_state = 2;
            end else begin
                for (int j = 0; j < K; j++)
                    if (m_addr + j < N) m_buf[m_addr + j] = bit'((d >> j) & 1);
                if (m_addr < N) m_addr += K;
            end
        end
    endtask

    // One clock: drive, let the edge pass, then compare with the model.
    task automatic step(bit v, int c, int d, bit f);
        @(negedge clk);
        code_valid = v;
        code_ctl   = c[1:0];
        code_data  = d[K-1:0];
        flush      = f;
        @(posedge clk);
        model_update(v, c, d, f);
        #(CLK_PERIOD/4);
        chk("R7 per-cycle done", {{(N-1){1'b0}}, slice_done}, {{(N-1){1'b0}}, exp_done});
        chk("R7 per-cycle slice", scan_slice, exp_slice);
        if (care_on && slice_done) begin
            logic [N-1:0] cv, cm;
            if (care_val_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 unexpected delivery actual=%h expected=none", scan_slice);
            end else begin
                cv = care_val_q.pop_front();
                cm = care_msk_q.pop_front();
                chk("R6 care bits of delivered slice", scan_slice & cm, cv & cm);
            end
        end
    endtask

    // Behavioural encoder for one slice; care: 0, 1 or 2 for don't care.
    task automatic encode(int care [N]);
        int ones = 0, zeros = 0, bg, tg, first = N, prev_g = -5;
        bit run_open = 1'b0;
        int ngrp = (N + K - 1) / K;
        for (int i = 0; i < N; i++) begin
            if (care[i] == 1) ones++;
            if (care[i] == 0) zeros++;
        end
        bg = (ones > zeros) ? 1 : 0;
        tg = 1 - bg;
        for (int g = 0; g < ngrp; g++) begin
            int cnt = 0, pos = 0;
            for (int j = 0; j < K; j++)
                if (g*K + j < N && care[g*K + j] == tg) begin cnt++; pos = g*K + j; end
            if (cnt == 1 && first == N) first = pos;
        end
        ctl_q.push_back(bg);
        dat_q.push_back(first);
        for (int g = 0; g < ngrp; g++) begin
            int cnt = 0, pos = 0;
            for (int j = 0; j < K; j++)
                if (g*K + j < N && care[g*K + j] == tg) begin cnt++; pos = g*K + j; end
            if (cnt > 1) begin
                int lit = 0;
                if (!(run_open && prev_g == g - 1)) begin
                    if (run_open) begin ctl_q.push_back(2); dat_q.push_back(N); end
                    ctl_q.push_back(3); dat_q.push_back(g*K);
                end
                for (int j = 0; j < K; j++) begin
                    int b;
                    if (g*K + j < N) b = (care[g*K + j] == 2) ? bg : care[g*K + j];
                    else b = $urandom_range(1);
                    lit |= b << j;
                end
                ctl_q.push_back(3); dat_q.push_back(lit);
                run_open = 1'b1;
                prev_g = g;
            end else if (cnt == 1 && pos != first) begin
                ctl_q.push_back(2); dat_q.push_back(pos);
                run_open = 1'b0;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_buf[i] = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 reset slice", scan_slice, '0);
        chk("R1 reset done", {{(N-1){1'b0}}, slice_done}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 slice after reset", scan_slice, '0);

        // R9: bit/group codes in idle are ignored; a flush then delivers nothing
        step(1, 2, 4, 0);
        step(1, 3, 0, 0);
        step(0, 0, 0, 1);
        chk("R9 no delivery from idle", {{(N-1){1'b0}}, slice_done}, '0);

        // R2: background 0, target at index 3
        step(1, 0, 3, 0);
        step(0, 0, 0, 1);
        chk("R2 initial 00 index 3", scan_slice, 16'h0008);
        chk("R8 flush strobe", {{(N-1){1'b0}}, slice_done}, 1);

        // R3: dummy index with background 1
        step(1, 1, N, 0);
        step(0, 0, 0, 1);
        chk("R3 dummy index keeps all background", scan_slice, 16'hFFFF);

        // R4: bit codes, one out of range
        step(1, 0, 0, 0);
        step(1, 2, 7, 0);
        step(1, 2, N, 0);
        step(0, 0, 0, 1);
        chk("R4 bit codes", scan_slice, 16'h0081);

        // R5: address load alone writes nothing
        step(1, 0, 20, 0);
        step(1, 3, 5, 0);
        step(0, 0, 0, 1);
        chk("R5 address load no write", scan_slice, 16'h0000);

        // R6: merged windows, separator, last window partly beyond the buffer
        step(1, 0, N, 0);
        step(1, 3, 0, 0);
        step(1, 3, 5'b10110, 0);
        step(1, 3, 5'b00111, 0);
        step(1, 2, N, 0);
        step(1, 3, 15, 0);
        step(1, 3, 5'b11111, 0);
        step(1, 1, 2, 0);
        chk("R6 group copy and drop beyond end", scan_slice, 16'h80F6);
        chk("R7 delivery on next initial code", {{(N-1){1'b0}}, slice_done}, 1);
        step(0, 0, 0, 0);
        chk("R7 strobe lasts one cycle", {{(N-1){1'b0}}, slice_done}, 0);
        step(1, 2, 2, 1);
        chk("R8 flush wins over same-cycle code", scan_slice, 16'hFFFB);

        // Random slices through the encoder
        care_on = 1'b1;
        for (int s = 0; s < NSL; s++) begin
            int care [N];
            logic [N-1:0] cv, cm;
            int dens = $urandom_range(5, 70);
            cv = '0; cm = '0;
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(99) < dens) begin
                    care[i] = $urandom_range(1);
                    cm[i] = 1'b1;
                    cv[i] = care[i][0];
                end else begin
                    care[i] = 2;
                end
            end
            care_val_q.push_back(cv);
            care_msk_q.push_back(cm);
            ctl_q.delete();
            dat_q.delete();
            encode(care);
            for (int k = 0; k < ctl_q.size(); k++)
                step(1, ctl_q[k], dat_q[k], 0);
            if ($urandom_range(3) == 0) step(0, 0, 0, 0);
        end
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        checks++;
        if (care_val_q.size() != 0) begin
            failures++;
            $display("FAIL R7 undelivered slices actual=%0d expected=0", care_val_q.size());
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule